// File: doc/BRIEF.md
# Hardware Thread Context Run-State Controller

This block keeps the run state of a small set of hardware thread contexts that share one core. Each context has its own state machine that moves on single-cycle command strobes: start (with a cycle delay), park, release and stop. From that state the block derives, for each context, whether instructions may issue. It also raises one global flag once every context has stopped for good.

Issue logic reads the per-context enable vector. Control logic sends the strobes, and for a start it sends a shared delay value. A start that is still counting down can be cancelled by a later command. A context that has stopped ignores everything until reset. When the global stopped flag rises, the surrounding system can end its run.

Top module: `thread_ctx_ctrl`

## Requirements
- R1: After reset every context is Unallocated, `issue_en` is all zeros and `all_halted` is low.
- R2: Each context reports a 2-bit code in `state_o[2*i+1:2*i]`: 0 = Unallocated, 1 = Active, 2 = Suspended, 3 = Halted.
- R3: `issue_en[i]` is high exactly when context i reports Active.
- R4: A start strobe sampled with `act_delay` = d turns the context Active after max(d,1) rising edges, counting the sampling edge. The state stays unchanged until then. A start to an already Active context has no effect.
- R5: A park strobe moves a non-Halted context to Suspended on the next edge. A later start can leave Suspended.
- R6: A release strobe returns a non-Halted context to Unallocated on the next edge.
- R7: A stop strobe moves a context to Halted. Halted is permanent: every strobe to a Halted context is ignored until reset.
- R8: When strobes to one context coincide, stop wins over release, release wins over park, and park wins over start.
- R9: Any new strobe to a context with a start still counting cancels the pending activation. A new start restarts the count with its own delay.
- R10: `all_halted` is high exactly when every context is Halted.
- R11: A strobe to one context never changes the state of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_act | input | NCTX | Start strobe per context |
| cmd_susp | input | NCTX | Park strobe per context |
| cmd_dealloc | input | NCTX | Release strobe per context |
| cmd_halt | input | NCTX | Stop strobe per context |
| act_delay | input | DLY_W | Activation delay in cycles, shared by all start strobes |
| state_o | output | 2*NCTX | Packed per-context state codes |
| issue_en | output | NCTX | Per-context issue permission |
| all_halted | output | 1 | Every context is Halted |

## Verification
The checker looks at every cycle for five things: stop strobes take effect, Halted stays Halted, release and park strobes land in their states, a start with zero or one cycle of delay lands in Active, and the stopped flag never coincides with an issue permission. The exact length of longer delays, cancelling or restarting a pending start, the full priority table across every starting state, and the independence of contexts show up only in the bench's sweeps. Those sweeps count edges and compare the full state vector.

// File: rtl/thread_ctx_ctrl.sv
module thread_ctx_ctrl #(
  parameter int NCTX  = 4,
  parameter int DLY_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCTX-1:0]   cmd_act,
  input  logic [NCTX-1:0]   cmd_susp,
  input  logic [NCTX-1:0]   cmd_dealloc,
  input  logic [NCTX-1:0]   cmd_halt,
  input  logic [DLY_W-1:0]  act_delay,
  output logic [2*NCTX-1:0] state_o,
  output logic [NCTX-1:0]   issue_en,
  output logic              all_halted
);
  localparam logic [1:0] S_UNAL = 2'd0;
  localparam logic [1:0] S_ACT  = 2'd1;
  localparam logic [1:0] S_SUSP = 2'd2;
  localparam logic [1:0] S_HALT = 2'd3;
  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  logic [NCTX-1:0] halted_v;

  for (genvar i = 0; i < NCTX; i++) begin : g_ctx
    logic [1:0]       st;
    logic             pend;
    logic [DLY_W-1:0] cnt;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st   <= S_UNAL;
        pend <= 1'b0;
        cnt  <= '0;
      end else if (st != S_HALT) begin
        if (cmd_halt[i]) begin
          st   <= S_HALT;
          pend <= 1'b0;
        end else if (cmd_dealloc[i]) begin
          st   <= S_UNAL;
          pend <= 1'b0;
        end else if (cmd_susp[i]) begin
          st   <= S_SUSP;
          pend <= 1'b0;
        end else if (cmd_act[i]) begin
          if (st != S_ACT) begin
            if (act_delay <= ONE) begin
              st   <= S_ACT;
              pend <= 1'b0;
            end else begin
              pend <= 1'b1;
              cnt  <= act_delay - ONE;
            end
          end
        end else if (pend) begin
          if (cnt == ONE) begin
            st   <= S_ACT;
            pend <= 1'b0;
          end else begin
            cnt <= cnt - ONE;
          end
        end
      end
    end

    assign state_o[2*i +: 2] = st;
    assign issue_en[i]       = (st == S_ACT);
    assign halted_v[i]       = (st == S_HALT);
  end

  assign all_halted = &halted_v;
endmodule

module thread_ctx_ctrl_chk #(
  parameter int NCTX  = 4,
  parameter int DLY_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCTX-1:0]   cmd_act,
  input logic [NCTX-1:0]   cmd_susp,
  input logic [NCTX-1:0]   cmd_dealloc,
  input logic [NCTX-1:0]   cmd_halt,
  input logic [DLY_W-1:0]  act_delay,
  input logic [2*NCTX-1:0] state_o,
  input logic [NCTX-1:0]   issue_en,
  input logic              all_halted
);
  a_r10_no_issue_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    all_halted |-> (issue_en == '0));

  for (genvar i = 0; i < NCTX; i++) begin : g_chk
    a_r7_halt_enters: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_halt[i] |=> (state_o[2*i +: 2] == 2'd3));
    a_r7_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o[2*i +: 2] == 2'd3) |=> (state_o[2*i +: 2] == 2'd3) && !issue_en[i]);
    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_dealloc[i] && !cmd_halt[i] && state_o[2*i +: 2] != 2'd3)
      |=> (state_o[2*i +: 2] == 2'd0));
    a_r5_park: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_susp[i] && !cmd_dealloc[i] && !cmd_halt[i] && state_o[2*i +: 2] != 2'd3)
      |=> (state_o[2*i +: 2] == 2'd2));
    a_r4_short_start: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_act[i] && !cmd_susp[i] && !cmd_dealloc[i] && !cmd_halt[i]
       && act_delay <= DLY_W'(1) && state_o[2*i +: 2] != 2'd3)
      |=> issue_en[i]);
  end
endmodule

bind thread_ctx_ctrl thread_ctx_ctrl_chk #(.NCTX(NCTX), .DLY_W(DLY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_act(cmd_act), .cmd_susp(cmd_susp),
  .cmd_dealloc(cmd_dealloc), .cmd_halt(cmd_halt), .act_delay(act_delay),
  .state_o(state_o), .issue_en(issue_en), .all_halted(all_halted)
);

// File: tb/thread_ctx_ctrl_tb.sv
module thread_ctx_ctrl_tb;
  localparam int N = 4;
  localparam int DW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] cmd_act = '0, cmd_susp = '0, cmd_dealloc = '0, cmd_halt = '0;
  logic [DW-1:0] act_delay = '0;
  logic [2*N-1:0] state_o;
  logic [N-1:0] issue_en;
  logic all_halted;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  thread_ctx_ctrl #(.NCTX(N), .DLY_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_act(cmd_act), .cmd_susp(cmd_susp),
    .cmd_dealloc(cmd_dealloc), .cmd_halt(cmd_halt), .act_delay(act_delay),
    .state_o(state_o), .issue_en(issue_en), .all_halted(all_halted));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clr();
    cmd_act = '0; cmd_susp = '0; cmd_dealloc = '0; cmd_halt = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    clr();
    rst_n = 1'b0;
    step(); step();
    rst_n = 1'b1;
  endtask

  function automatic int st(input int i);
    return int'(state_o[2*i +: 2]);
  endfunction

  task automatic pulse(input logic [3:0] hdsa, input int i, input int d);
    act_delay = DW'(d);
    cmd_halt[i] = hdsa[3]; cmd_dealloc[i] = hdsa[2];
    cmd_susp[i] = hdsa[1]; cmd_act[i] = hdsa[0];
    step();
    clr();
  endtask

  function automatic int iss_of_state(input logic [2*N-1:0] s);
    int v = 0;
    for (int i = 0; i < N; i++) if (s[2*i +: 2] == 2'd1) v |= (1 << i);
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 state", int'(state_o), 0);
    chk("R1 issue", int'(issue_en), 0);
    chk("R1 all_halted", int'(all_halted), 0);

    // R4 delay sweep on ctx0, R11 others untouched, R3 issue tracks state
    for (int d = 0; d < 16; d++) begin
      int e;
      do_reset();
      e = (d == 0) ? 1 : d;
      pulse(4'b0001, 0, d);
      for (int n = 1; n <= 16; n++) begin
        chk($sformatf("R4 d=%0d n=%0d", d, n), st(0), (n >= e) ? 1 : 0);
        chk("R3 issue", int'(issue_en), iss_of_state(state_o));
        chk("R11 others", int'(state_o[2*N-1:2]), 0);
        step();
      end
    end

    // R8 priority table across starting states, R2 codes, on ctx1
    for (int s0 = 0; s0 < 3; s0++) begin
      for (int c = 0; c < 16; c++) begin
        int exp;
        do_reset();
        if (s0 == 1) pulse(4'b0001, 1, 1);
        if (s0 == 2) pulse(4'b0010, 1, 1);
        chk("R2 start code", st(1), s0);
        pulse(4'(c), 1, 1);
        if (c[3]) exp = 3;
        else if (c[2]) exp = 0;
        else if (c[1]) exp = 2;
        else if (c[0]) exp = 1;
        else exp = s0;
        chk($sformatf("R8 s0=%0d cmd=%0d", s0, c), st(1), exp);
        chk("R3 issue", int'(issue_en[1]), (exp == 1) ? 1 : 0);
        chk("R11 neighbours", int'(state_o) & ~(3 << 2), 0);
      end
    end

    // R5 park then resume; R4 start on Active has no effect
    do_reset();
    pulse(4'b0001, 2, 1);
    pulse(4'b0010, 2, 1);
    chk("R5 parked", st(2), 2);
    pulse(4'b0001, 2, 3);
    chk("R5 still parked", st(2), 2);
    step();
    chk("R5 still parked", st(2), 2);
    step();
    chk("R5 resumed", st(2), 1);
    pulse(4'b0001, 2, 5);
    for (int n = 0; n < 6; n++) begin
      chk("R4 start on active", st(2), 1);
      step();
    end

    // R9 cancel by park and by release; restart by new start
    do_reset();
    pulse(4'b0001, 3, 5);
    step();
    pulse(4'b0010, 3, 1);
    for (int n = 0; n < 8; n++) begin chk("R9 cancel park", st(3), 2); step(); end
    pulse(4'b0001, 3, 6);
    step();
    pulse(4'b0100, 3, 1);
    for (int n = 0; n < 8; n++) begin chk("R9 cancel release", st(3), 0); step(); end
    pulse(4'b0001, 3, 4);
    step();
    pulse(4'b0001, 3, 6);
    for (int n = 1; n <= 8; n++) begin
      chk($sformatf("R9 restart n=%0d", n), st(3), (n >= 6) ? 1 : 0);
      step();
    end

    // R7 halted ignores everything; R10 all_halted
    do_reset();
    pulse(4'b0001, 0, 1);
    pulse(4'b1000, 0, 1);
    for (int c = 0; c < 8; c++) begin
      pulse(4'(c), 0, 1);
      chk("R7 halted sticky", st(0), 3);
      chk("R7 no issue", int'(issue_en[0]), 0);
    end
    pulse(4'b0001, 0, 3);
    repeat (4) step();
    chk("R7 late start ignored", st(0), 3);
    for (int i = 1; i < N; i++) begin
      chk("R10 not yet", int'(all_halted), 0);
      pulse(4'b1000, i, 1);
    end
    chk("R10 all halted", int'(all_halted), 1);
    chk("R10 issue off", int'(issue_en), 0);
    do_reset();
    chk("R1 after halt", int'(all_halted), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule